// File: doc/BRIEF.md
# Shared Gate Schedule Sequencer

This block drives per-port, per-traffic-class transmit gates from one gate schedule table that every egress port shares. Up to eight execution threads each own a contiguous slice of that table. A slice starts at the thread's entry address and ends at the thread's end index. Each thread waits until a common schedule time plus its own start offset. It then walks its slice, holding each entry for that entry's hold time in ticks, and returns to its entry address after the end index. Each table entry names the ports it affects, the traffic classes it blocks, and whether the blocking mask is enabled.

Software loads the table, the per-thread entry points and end indices, and the active thread count through one write port while the sequencer is idle. It then selects a clock source and pulses start. The tick counter input is free running. It is compared against start and expiry times in a way that tolerates counter wrap. Each hold interval is added to the previous expiry, so the schedule does not drift. Where two or more live threads cover the same port, the gate vectors they produce are ANDed.

Top module: `gate_list_seq`

## Requirements
- R1: After reset the sequencer is idle, no thread is live, and every bit of `gate_open_o` is 1.
- R2: Thread i becomes live in the first cycle after `time_i` reaches `sched_time_i` plus its start offset, and it begins at its entry address. Before that it contributes all-open gates.
- R3: A live thread holds each entry for exactly that entry's hold time in ticks. It then steps to the next table index.
- R4: A thread at its end index steps back to its entry address.
- R5: Entry layout is: bits [7:0] blocked-class mask (bit c = class c), bit 8 mask enable, bits [13:9] destination ports (bit p = port p), bits [32:14] hold time. While an entry is current with its mask enabled, the gates of each destination port are the inverse of the mask. Ports outside the destination set are not affected.
- R6: An entry whose mask enable is 0 leaves all gates open.
- R7: The active thread count holds the number of threads in use minus one. Threads with an index above it never go live.
- R8: On a port covered by several live threads, the open gates are the bitwise AND of each thread's gate vector.
- R9: Clock source code 0 means disabled, and codes 1, 2 and 3 all run from `time_i`. A source of 0 returns the sequencer to idle, and all gates open one cycle later. A start pulse while the source is 0 has no effect.
- R10: Write selects are: 0 = table entry at `wr_addr_i`; 1 = entry point of thread `wr_addr_i`, with the entry address in data [3:0] and the start offset in data [22:4]; 2 = end index of thread `wr_addr_i` in data [3:0]; 3 = active count in data [2:0]. Writes are accepted only while idle.
- R11: A start pulse with a nonzero source clears every thread and re-arms it, so each thread restarts from its entry address at its start time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 32 | Free-running tick counter |
| sched_time_i | input | 32 | Common schedule start time |
| clk_src_i | input | 2 | Clock source select (0 disables) |
| start_i | input | 1 | Start / re-arm pulse |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Configuration write target |
| wr_addr_i | input | 4 | Table index or thread number |
| wr_data_i | input | 33 | Write data |
| gate_open_o | output | 40 | Gate open per port and class, port p at bits [8p+7:8p] |

## Verification
The assertions check on every cycle that a live thread's index stays inside its slice and moves only by one or back to its entry address. They also check that a thread outside the active count or an idle sequencer never has a live thread, that the table is frozen while running, and that gates are all open when no thread is live. The exact tick at which each thread starts and steps, the mask inversion per destination port, the ANDing of overlapping threads, and the re-arm after a write made while idle can only be shown by the bench. It walks a three-thread schedule tick by tick and compares each port's gate byte against hand-computed values.

// File: rtl/gls_pkg.sv
package gls_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY  = 2'd0,
    SEL_EPOINT = 2'd1,
    SEL_END    = 2'd2,
    SEL_ACT    = 2'd3
  } wsel_e;

  localparam logic [1:0] SRC_OFF = 2'd0;
endpackage

// File: rtl/gls_cfg.sv
module gls_cfg
  import gls_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_TC    = 8,
  parameter int NUM_THR   = 8,
  parameter int DEPTH     = 16,
  parameter int DELTA_W   = 19,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int THR_W    = $clog2(NUM_THR),
  localparam int WA_W     = (ADDR_W > THR_W) ? ADDR_W : THR_W,
  localparam int ENTRY_W  = NUM_TC + 1 + NUM_PORTS + DELTA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        running_i,
  input  logic                        wr_en_i,
  input  logic [1:0]                  wr_sel_i,
  input  logic [WA_W-1:0]             wr_addr_i,
  input  logic [ENTRY_W-1:0]          wr_data_i,
  output logic [DEPTH*ENTRY_W-1:0]    tbl_o,
  output logic [NUM_THR*ADDR_W-1:0]   ep_addr_o,
  output logic [NUM_THR*DELTA_W-1:0]  ep_delta_o,
  output logic [NUM_THR*ADDR_W-1:0]   end_o,
  output logic [THR_W-1:0]            act_o
);
  logic [ENTRY_W-1:0] tbl_q    [DEPTH];
  logic [ADDR_W-1:0]  ep_addr_q[NUM_THR];
  logic [DELTA_W-1:0] ep_dly_q [NUM_THR];
  logic [ADDR_W-1:0]  end_q    [NUM_THR];
  logic [THR_W-1:0]   act_q;
  logic               wr_ok;
  wsel_e              sel;

  assign wr_ok = wr_en_i && !running_i;
  assign sel   = wsel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) tbl_q[k] <= '0;
      for (int t = 0; t < NUM_THR; t++) begin
        ep_addr_q[t] <= '0;
        ep_dly_q[t]  <= '0;
        end_q[t]     <= '0;
      end
      act_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_ENTRY:  tbl_q[wr_addr_i[ADDR_W-1:0]] <= wr_data_i;
        SEL_EPOINT: begin
          ep_addr_q[wr_addr_i[THR_W-1:0]] <= wr_data_i[ADDR_W-1:0];
          ep_dly_q[wr_addr_i[THR_W-1:0]]  <= wr_data_i[ADDR_W +: DELTA_W];
        end
        SEL_END:    end_q[wr_addr_i[THR_W-1:0]] <= wr_data_i[ADDR_W-1:0];
        default:    act_q <= wr_data_i[THR_W-1:0];
      endcase
    end
  end

  assign act_o = act_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    assign tbl_o[k*ENTRY_W +: ENTRY_W] = tbl_q[k];
    // R10: table cannot change while the sequencer runs
    a_r10_tbl_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      running_i |=> $stable(tbl_q[k]));
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign ep_addr_o[t*ADDR_W +: ADDR_W]    = ep_addr_q[t];
    assign ep_delta_o[t*DELTA_W +: DELTA_W] = ep_dly_q[t];
    assign end_o[t*ADDR_W +: ADDR_W]        = end_q[t];
  end

  a_r10_act_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_i |=> $stable(act_q));
endmodule

// File: rtl/gls_thread.sv
module gls_thread #(
  parameter int NUM_PORTS = 5,
  parameter int NUM_TC    = 8,
  parameter int DEPTH     = 16,
  parameter int DELTA_W   = 19,
  parameter int TIME_W    = 32,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int ENTRY_W  = NUM_TC + 1 + NUM_PORTS + DELTA_W,
  localparam int EN_BIT   = NUM_TC,
  localparam int PORT_LSB = NUM_TC + 1,
  localparam int DLT_LSB  = NUM_TC + 1 + NUM_PORTS,
  localparam int GATE_W   = NUM_PORTS * NUM_TC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     rearm_i,
  input  logic                     active_i,
  input  logic [TIME_W-1:0]        time_i,
  input  logic [TIME_W-1:0]        sched_i,
  input  logic [ADDR_W-1:0]        ep_addr_i,
  input  logic [DELTA_W-1:0]       ep_delta_i,
  input  logic [ADDR_W-1:0]        end_i,
  input  logic [DEPTH*ENTRY_W-1:0] tbl_i,
  output logic                     live_o,
  output logic [GATE_W-1:0]        gate_o
);
  logic               live_q;
  logic [ADDR_W-1:0]  idx_q, nxt_idx;
  logic [TIME_W-1:0]  due_q, start_at;
  logic [NUM_TC-1:0]  cur_mask;
  logic               cur_en;
  logic [NUM_PORTS-1:0] cur_ports;

  // wrap-tolerant "now >= due"
  function automatic logic reached(input logic [TIME_W-1:0] now, input logic [TIME_W-1:0] due);
    logic [TIME_W-1:0] d;
    d = now - due;
    return !d[TIME_W-1];
  endfunction

  function automatic logic [TIME_W-1:0] hold_of(input logic [ADDR_W-1:0] idx);
    return TIME_W'(tbl_i[int'(idx)*ENTRY_W + DLT_LSB +: DELTA_W]);
  endfunction

  assign start_at  = sched_i + TIME_W'(ep_delta_i);
  assign nxt_idx   = (idx_q == end_i) ? ep_addr_i : idx_q + 1'b1;
  assign cur_mask  = tbl_i[int'(idx_q)*ENTRY_W +: NUM_TC];
  assign cur_en    = tbl_i[int'(idx_q)*ENTRY_W + EN_BIT];
  assign cur_ports = tbl_i[int'(idx_q)*ENTRY_W + PORT_LSB +: NUM_PORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      idx_q  <= '0;
      due_q  <= '0;
    end else if (rearm_i || !run_i || !active_i) begin
      live_q <= 1'b0;
    end else if (!live_q) begin
      if (reached(time_i, start_at)) begin
        live_q <= 1'b1;
        idx_q  <= ep_addr_i;
        due_q  <= start_at + hold_of(ep_addr_i);
      end
    end else if (reached(time_i, due_q)) begin
      idx_q <= nxt_idx;
      due_q <= due_q + hold_of(nxt_idx);
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      gate_o[p*NUM_TC +: NUM_TC] = (live_q && cur_en && cur_ports[p]) ? ~cur_mask : '1;
  end

  assign live_o = live_q;

  a_r4_idx_in_slice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (idx_q >= ep_addr_i && idx_q <= end_i));
  a_r3_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(live_q) && idx_q != $past(idx_q)) |->
      (idx_q == $past(idx_q) + 1'b1 || idx_q == ep_addr_i));
  a_r9_idle_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !live_q);
  a_r7_inactive_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !live_q);
endmodule

// File: rtl/gls_merge.sv
module gls_merge #(
  parameter int NUM_THR = 8,
  parameter int GATE_W  = 40
) (
  input  logic [NUM_THR*GATE_W-1:0] gate_i,
  output logic [GATE_W-1:0]         gate_o
);
  always_comb begin
    gate_o = '1;
    for (int t = 0; t < NUM_THR; t++) gate_o &= gate_i[t*GATE_W +: GATE_W];
  end
endmodule

// File: rtl/gate_list_seq.sv
module gate_list_seq
  import gls_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_TC    = 8,
  parameter int NUM_THR   = 8,
  parameter int DEPTH     = 16,
  parameter int DELTA_W   = 19,
  parameter int TIME_W    = 32,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int THR_W    = $clog2(NUM_THR),
  localparam int WA_W     = (ADDR_W > THR_W) ? ADDR_W : THR_W,
  localparam int ENTRY_W  = NUM_TC + 1 + NUM_PORTS + DELTA_W,
  localparam int GATE_W   = NUM_PORTS * NUM_TC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TIME_W-1:0]  time_i,
  input  logic [TIME_W-1:0]  sched_time_i,
  input  logic [1:0]         clk_src_i,
  input  logic               start_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [WA_W-1:0]    wr_addr_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  output logic [GATE_W-1:0]  gate_open_o
);
  logic                       running_q, src_on;
  logic [DEPTH*ENTRY_W-1:0]   tbl;
  logic [NUM_THR*ADDR_W-1:0]  ep_addr, end_idx;
  logic [NUM_THR*DELTA_W-1:0] ep_delta;
  logic [THR_W-1:0]           act;
  logic [NUM_THR-1:0]         live;
  logic [NUM_THR*GATE_W-1:0]  thr_gate;

  assign src_on = (clk_src_i != SRC_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           running_q <= 1'b0;
    else if (!src_on)      running_q <= 1'b0;
    else if (start_i)      running_q <= 1'b1;
  end

  gls_cfg #(
    .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC), .NUM_THR(NUM_THR),
    .DEPTH(DEPTH), .DELTA_W(DELTA_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .running_i (running_q),
    .wr_en_i, .wr_sel_i, .wr_addr_i, .wr_data_i,
    .tbl_o     (tbl),
    .ep_addr_o (ep_addr),
    .ep_delta_o(ep_delta),
    .end_o     (end_idx),
    .act_o     (act)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    gls_thread #(
      .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC), .DEPTH(DEPTH),
      .DELTA_W(DELTA_W), .TIME_W(TIME_W)
    ) u_thr (
      .clk_i, .rst_ni,
      .run_i     (running_q),
      .rearm_i   (start_i && src_on),
      .active_i  (THR_W'(t) <= act),
      .time_i,
      .sched_i   (sched_time_i),
      .ep_addr_i (ep_addr[t*ADDR_W +: ADDR_W]),
      .ep_delta_i(ep_delta[t*DELTA_W +: DELTA_W]),
      .end_i     (end_idx[t*ADDR_W +: ADDR_W]),
      .tbl_i     (tbl),
      .live_o    (live[t]),
      .gate_o    (thr_gate[t*GATE_W +: GATE_W])
    );
  end

  gls_merge #(.NUM_THR(NUM_THR), .GATE_W(GATE_W)) u_merge (
    .gate_i(thr_gate),
    .gate_o(gate_open_o)
  );

  a_r1_no_live_all_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|live) |-> (&gate_open_o));
  a_r9_live_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|live) |-> $past(running_q));
endmodule

// File: tb/gate_list_seq_tb_top.sv
`timescale 1ns/1ps
module gate_list_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_v = 32'd100;
  logic [31:0] sched = 32'd100;
  logic [1:0]  src = 2'd0;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [3:0]  wr_addr = '0;
  logic [32:0] wr_data = '0;
  logic [39:0] gates;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gate_list_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_v), .sched_time_i(sched),
    .clk_src_i(src), .start_i(start), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .gate_open_o(gates)
  );

  function automatic logic [32:0] mk_entry(int hold, logic [4:0] ports, logic en, logic [7:0] mask);
    return {19'(hold), ports, en, mask};
  endfunction

  task automatic wr(logic [1:0] sel, int addr, logic [32:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // step time one tick per clock, then sample one edge later
  task automatic advance_to(int target);
    for (int t = int'(time_v) + 1; t <= target; t++) begin
      @(negedge clk); time_v = 32'(t);
    end
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2,
                       logic [7:0] e3, logic [7:0] e4);
    logic [39:0] exp_v;
    exp_v = {e4, e3, e2, e1, e0};
    n_run++;
    if (gates !== exp_v) begin
      n_fail++;
      $display("FAIL %s t=%0d gates=%h expected=%h", req, time_v, gates, exp_v);
    end
  endtask

  task automatic t_reset();
    check("R1", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
  endtask

  task automatic t_config();
    // R10 encodings: entries, entry points, end indices, active count
    wr(2'd0, 0, mk_entry(5, 5'b00001, 1'b1, 8'h0F));
    wr(2'd0, 1, mk_entry(3, 5'b00001, 1'b1, 8'hF0));
    wr(2'd0, 2, mk_entry(2, 5'b00011, 1'b0, 8'hFF));
    wr(2'd0, 3, mk_entry(4, 5'b00110, 1'b1, 8'h01));
    wr(2'd0, 4, mk_entry(4, 5'b00100, 1'b1, 8'h80));
    wr(2'd0, 5, mk_entry(7, 5'b00100, 1'b1, 8'h02));
    wr(2'd0, 6, mk_entry(1, 5'b11111, 1'b1, 8'hFF));
    wr(2'd1, 0, {10'd0, 19'd10, 4'd0});
    wr(2'd1, 1, {10'd0, 19'd20, 4'd3});
    wr(2'd1, 2, {10'd0, 19'd20, 4'd5});
    wr(2'd1, 3, {10'd0, 19'd0,  4'd6});
    wr(2'd2, 0, 33'd2);
    wr(2'd2, 1, 33'd4);
    for (int t = 2; t < 8; t++) wr(2'd2, t, 33'd5);
    wr(2'd3, 0, 33'd2);
  endtask

  task automatic t_run();
    src = 2'd1;
    pulse_start();
    advance_to(109);
    check("R2 R7 before start", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    advance_to(110);
    check("R2 R5 thread0 start", 8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    advance_to(114);
    check("R3 hold", 8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    advance_to(115);
    check("R3 step", 8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    advance_to(118);
    check("R6 mask disabled", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    advance_to(120);
    check("R4 R8 wrap and overlap", 8'hF0, 8'hFE, 8'hFC, 8'hFF, 8'hFF);
    advance_to(124);
    check("R5 R8 dest only", 8'hF0, 8'hFF, 8'h7D, 8'hFF, 8'hFF);
    advance_to(125);
    check("R3 second lap", 8'h0F, 8'hFF, 8'h7D, 8'hFF, 8'hFF);
    wr(2'd0, 0, mk_entry(5, 5'b00001, 1'b1, 8'h00));
    advance_to(128);
    check("R4 thread1 wrap", 8'hFF, 8'hFE, 8'hFC, 8'hFF, 8'hFF);
    advance_to(130);
    check("R10 write ignored while running", 8'hF0, 8'hFE, 8'hFC, 8'hFF, 8'hFF);
  endtask

  task automatic t_disable_restart();
    @(negedge clk); src = 2'd0;
    @(negedge clk);
    @(negedge clk);
    check("R9 source off", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    pulse_start();
    advance_to(135);
    check("R9 start ignored", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    wr(2'd0, 0, mk_entry(5, 5'b00001, 1'b1, 8'h3C));
    sched = 32'd200;
    src = 2'd2;
    pulse_start();
    advance_to(209);
    check("R11 before restart", 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    advance_to(210);
    check("R11 R10 restart with new entry", 8'hC3, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    // re-arm mid-run: thread0 goes back to entry address at its start time
    advance_to(216);
    check("R11 mid run", 8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    pulse_start();
    @(negedge clk);
    check("R11 rearm from entry", 8'hC3, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_run();
    t_disable_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule